// File: doc/BRIEF.md
# Universal Shift Register with Shared Bus Port

This block is an eight-bit register that can keep its value, shift one place toward either end, or load a whole word. Load data and read-out data share one parallel port. That port is modelled as three signals: a data input, a data output and a drive enable that says when the register owns the bus. Two mode inputs pick the operation on each rising clock edge. Two active-low enables decide whether the stored word is put on the bus. Choosing parallel load always releases the bus, so that another agent can present the word to be captured.

A serial input sits at each end of the register and feeds the bit that is vacated during a shift. The two end bits are always brought out as serial outputs, so several blocks can be chained into a longer shifter. An active-low asynchronous reset clears the register and takes priority over every other input.

Top module: `ushift_bus_reg`

## Requirements
- R1: While `rst_n` is low the register is zero (`bus_out` = 0x00). The clear happens without a clock edge and overrides every mode.
- R2: With `mode_b`=0 and `mode_a`=0 the register keeps its value across a rising edge, whatever `bus_in` and the serial inputs are.
- R3: With `mode_b`=0 and `mode_a`=1, each bit i takes the value of bit i-1 on the rising edge, and bit 0 takes `ser_lo_in`.
- R4: With `mode_b`=1 and `mode_a`=0, each bit i takes the value of bit i+1 on the rising edge, and bit 7 takes `ser_hi_in`.
- R5: With `mode_b`=1 and `mode_a`=1, the register captures `bus_in` on the rising edge.
- R6: `bus_drive` is 1 exactly when `oe0_n`=0, `oe1_n`=0 and the mode is not load (mode_b=1, mode_a=1). `bus_out` carries the stored word.
- R7: `ser_lo_out` equals bit 0 and `ser_hi_out` equals bit 7 at all times, whatever the output enables are.
- R8: The inputs are sampled on the rising edge. The first edge after reset is released acts on the cleared register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| mode_a | input | 1 | Mode select, low bit |
| mode_b | input | 1 | Mode select, high bit |
| oe0_n | input | 1 | Active-low output enable, first |
| oe1_n | input | 1 | Active-low output enable, second |
| ser_lo_in | input | 1 | Serial bit entering at bit 0 |
| ser_hi_in | input | 1 | Serial bit entering at bit 7 |
| bus_in | input | 8 | Word seen on the shared bus |
| bus_out | output | 8 | Stored word offered to the bus |
| bus_drive | output | 1 | Register drives the bus when 1 |
| ser_lo_out | output | 1 | Bit 0 of the register |
| ser_hi_out | output | 1 | Bit 7 of the register |

## Verification
The assertions assume that the mode, bus and serial inputs are stable around each rising edge, and that `rst_n` is low from time zero. The update checks wait one clean edge after reset is released before they compare anything with the past. The bench therefore changes its inputs only on falling edges and drives reset low before the first clock. It makes its asynchronous-reset check between edges, so that no sampled value ever meets an input that is changing.

// File: rtl/ushift_bus_pkg.sv
package ushift_bus_pkg;
   // Encoding is {mode_b, mode_a}
   typedef enum logic [1:0] {
      OP_KEEP = 2'b00,
      OP_UP   = 2'b01,
      OP_DOWN = 2'b10,
      OP_LOAD = 2'b11
   } ushift_op_e;
endpackage

// File: rtl/ushift_mode_dec.sv
module ushift_mode_dec
   import ushift_bus_pkg::*;
(
   input  logic       mode_a,
   input  logic       mode_b,
   output ushift_op_e op,
   output logic       is_load
);
   always_comb begin
      op      = ushift_op_e'({mode_b, mode_a});
      is_load = (op == OP_LOAD);
   end
endmodule

// File: rtl/ushift_bit_cell.sv
module ushift_bit_cell
   import ushift_bus_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  ushift_op_e op,
   input  logic       from_lower,
   input  logic       from_upper,
   input  logic       par_in,
   output logic       q
);
   logic nxt;

   always_comb begin
      unique case (op)
         OP_UP:   nxt = from_lower;
         OP_DOWN: nxt = from_upper;
         OP_LOAD: nxt = par_in;
         default: nxt = q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= nxt;
   end
endmodule

// File: rtl/ushift_port_ctl.sv
module ushift_port_ctl (
   input  logic oe0_n,
   input  logic oe1_n,
   input  logic is_load,
   output logic drive
);
   always_comb drive = !oe0_n && !oe1_n && !is_load;
endmodule

// File: rtl/ushift_bus_reg.sv
module ushift_bus_reg
   import ushift_bus_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_a,
   input  logic             mode_b,
   input  logic             oe0_n,
   input  logic             oe1_n,
   input  logic             ser_lo_in,
   input  logic             ser_hi_in,
   input  logic [WIDTH-1:0] bus_in,
   output logic [WIDTH-1:0] bus_out,
   output logic             bus_drive,
   output logic             ser_lo_out,
   output logic             ser_hi_out
);
   localparam int CHAIN_W = WIDTH + 2;

   initial begin
      assert (WIDTH >= 2) else $error("WIDTH must be at least 2");
   end

   ushift_op_e         op;
   logic               is_load;
   logic [WIDTH-1:0]   q;
   logic [CHAIN_W-1:0] chain;

   ushift_mode_dec u_dec (
      .mode_a  (mode_a),
      .mode_b  (mode_b),
      .op      (op),
      .is_load (is_load)
   );

   // chain[0] feeds bit 0 from below, chain[WIDTH+1] feeds the top bit
   assign chain = {ser_hi_in, q, ser_lo_in};

   for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      ushift_bit_cell u_cell (
         .clk        (clk),
         .rst_n      (rst_n),
         .op         (op),
         .from_lower (chain[i]),
         .from_upper (chain[i+2]),
         .par_in     (bus_in[i]),
         .q          (q[i])
      );
   end

   ushift_port_ctl u_port (
      .oe0_n   (oe0_n),
      .oe1_n   (oe1_n),
      .is_load (is_load),
      .drive   (bus_drive)
   );

   assign bus_out    = q;
   assign ser_lo_out = q[0];
   assign ser_hi_out = q[WIDTH-1];

   // One clean edge must pass after reset before looking into the past
   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |-> bus_out == '0);

   p_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !mode_a && !mode_b) |=> $stable(bus_out));

   p_shift_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && mode_a && !mode_b) |=>
         bus_out == {$past(bus_out[WIDTH-2:0]), $past(ser_lo_in)});

   p_shift_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !mode_a && mode_b) |=>
         bus_out == {$past(ser_hi_in), $past(bus_out[WIDTH-1:1])});

   p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && mode_a && mode_b) |=> bus_out == $past(bus_in));

   p_release_on_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_a && mode_b) |-> !bus_drive);
endmodule

// File: tb/ushift_bus_reg_bench.sv
module ushift_bus_reg_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_a = 1'b0, mode_b = 1'b0;
   logic       oe0_n = 1'b1, oe1_n = 1'b1;
   logic       ser_lo_in = 1'b0, ser_hi_in = 1'b0;
   logic [7:0] bus_in = 8'h00;
   logic [7:0] bus_out;
   logic       bus_drive, ser_lo_out, ser_hi_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   ushift_bus_reg u_ushift_bus_reg (
      .clk(clk), .rst_n(rst_n), .mode_a(mode_a), .mode_b(mode_b),
      .oe0_n(oe0_n), .oe1_n(oe1_n), .ser_lo_in(ser_lo_in),
      .ser_hi_in(ser_hi_in), .bus_in(bus_in), .bus_out(bus_out),
      .bus_drive(bus_drive), .ser_lo_out(ser_lo_out), .ser_hi_out(ser_hi_out)
   );

   // Fields: {mode_b, mode_a, oe1_n, oe0_n, ser_hi_in, ser_lo_in}, bus_in, expected word, expected drive
   localparam logic [22:0] VEC [14] = '{
      {6'b11_00_00, 8'hA5, 8'hA5, 1'b0},
      {6'b00_00_00, 8'hFF, 8'hA5, 1'b1},
      {6'b01_00_01, 8'h00, 8'h4B, 1'b1},
      {6'b01_10_00, 8'h00, 8'h96, 1'b0},
      {6'b10_01_10, 8'h00, 8'hCB, 1'b0},
      {6'b10_00_00, 8'h00, 8'h65, 1'b1},
      {6'b11_00_00, 8'h3C, 8'h3C, 1'b0},
      {6'b00_11_00, 8'h00, 8'h3C, 1'b0},
      {6'b01_01_01, 8'h00, 8'h79, 1'b0},
      {6'b10_00_00, 8'h00, 8'h3C, 1'b1},
      {6'b11_00_00, 8'h80, 8'h80, 1'b0},
      {6'b01_00_00, 8'h00, 8'h00, 1'b1},
      {6'b11_00_00, 8'h01, 8'h01, 1'b0},
      {6'b10_00_00, 8'h00, 8'h00, 1'b1}
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   function automatic string mode_tag(input logic [1:0] m);
      case (m)
         2'b00:   return "R2";
         2'b01:   return "R3";
         2'b10:   return "R4";
         default: return "R5";
      endcase
   endfunction

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      // Reset state, R1
      repeat (2) @(negedge clk);
      check("R1 reset word", bus_out, 8'h00);
      check("R6 drive in reset with enables high", {7'd0, bus_drive}, 8'h00);
      rst_n = 1'b1;

      for (int k = 0; k < 14; k++) begin
         @(negedge clk);
         {mode_b, mode_a, oe1_n, oe0_n, ser_hi_in, ser_lo_in} = VEC[k][22:17];
         bus_in = VEC[k][16:9];
         #1;
         check("R6 drive enable", {7'd0, bus_drive}, {7'd0, VEC[k][0]});
         @(posedge clk);
         #2;
         check(mode_tag(VEC[k][22:21]), bus_out, VEC[k][8:1]);
         check("R7 serial ends", {6'd0, ser_hi_out, ser_lo_out},
               {6'd0, VEC[k][8], VEC[k][1]});
      end

      // R7 with enables released: ends still follow the word
      @(negedge clk);
      {mode_b, mode_a} = 2'b11; bus_in = 8'h81; oe0_n = 1'b1; oe1_n = 1'b1;
      @(posedge clk); #2;
      check("R7 ends with enables high", {6'd0, ser_hi_out, ser_lo_out}, 8'h03);

      // R1 asynchronous clear between edges
      @(negedge clk);
      {mode_b, mode_a} = 2'b11; bus_in = 8'hFF;
      @(posedge clk); #2;
      check("R5 load before clear", bus_out, 8'hFF);
      #1 rst_n = 1'b0;
      #1;
      check("R1 async clear without edge", bus_out, 8'h00);
      @(posedge clk); #2;
      check("R1 clear overrides load mode", bus_out, 8'h00);

      // R8 first edge after release acts on the cleared word
      @(negedge clk);
      {mode_b, mode_a} = 2'b01; ser_lo_in = 1'b1; rst_n = 1'b1;
      @(posedge clk); #2;
      check("R8 first edge shifts cleared word", bus_out, 8'h01);

      // R2 hold ignores bus and serial inputs
      @(negedge clk);
      {mode_b, mode_a} = 2'b00; bus_in = 8'hEE; ser_lo_in = 1'b1; ser_hi_in = 1'b1;
      oe0_n = 1'b0; oe1_n = 1'b0;
      repeat (3) @(posedge clk);
      #2;
      check("R2 hold over three edges", bus_out, 8'h01);
      check("R6 drive in hold", {7'd0, bus_drive}, 8'h01);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule